// File: doc/BRIEF.md
# Blank-Paced Chunk Copier

This block moves a region of memory in fixed 16-byte chunks. It does not copy a whole region at once. Each chunk waits for a horizontal-blank pulse from the video timing. Software first loads a source address, a destination address and a byte count through a start strobe. The engine then waits for blank pulses. On each pulse that comes while blank-paced mode is selected, on a visible line (line number below 144), with data still left to move, it copies one chunk through a byte-wide memory port.

Each byte takes a read cycle and then a write cycle. After the sixteenth write, the engine holds the processor stall line high for a fixed time: 8 clocks at normal speed, or 16 clocks when the double-speed input is high. After that it returns to waiting. The memory is a synchronous byte memory outside the block. Read data must be valid in the cycle after the read strobe.

Top module: `line_gap_dma`

## Requirements
- R1: A chunk starts only on a cycle where `blankPulse` is high, `blankMode` is 1, the remaining length is non-zero and `lineNum` is below 144; otherwise the pulse causes no memory access.
- R2: Each accepted pulse causes exactly 16 reads and 16 writes. The byte read from the source address is written to the destination address.
- R3: The source and destination addresses each rise by one after every byte, and carry on from chunk to chunk.
- R4: The remaining length drops by 16 after every chunk. The low 4 bits of `startLen` are ignored, so a length of 20 moves one chunk.
- R5: After the last write of a chunk, `cpuStall` is high for exactly 8 consecutive cycles when `fastClock` is 0, or 16 when it is 1. No memory access happens while it is high.
- R6: `busy` is high whenever the remaining length is non-zero. It falls after the last chunk's final write.
- R7: Every write comes in the cycle right after a read, and reads and writes are never active in the same cycle.
- R8: A blank pulse or a start strobe that arrives while a chunk is being copied or the stall is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| blankPulse | input | 1 | One-cycle horizontal-blank event |
| lineNum | input | 8 | Current scanline number |
| blankMode | input | 1 | 1 selects blank-paced transfers |
| fastClock | input | 1 | 1 selects double-speed (16-clock stall) |
| startReq | input | 1 | Load a new transfer (taken only while idle) |
| startSrc | input | 16 | Source start address |
| startDst | input | 16 | Destination start address |
| startLen | input | 16 | Byte count; low 4 bits ignored |
| memRdEn | output | 1 | Read strobe |
| memRdAddr | output | 16 | Read address |
| memRdData | input | 8 | Read data, valid the cycle after the strobe |
| memWrEn | output | 1 | Write strobe |
| memWrAddr | output | 16 | Write address |
| memWrData | output | 8 | Write data |
| cpuStall | output | 1 | Processor stall after each chunk |
| busy | output | 1 | Remaining length non-zero |

## Verification
The bench sends blank pulses on lines 10, 143 and 144, in both modes and at both speeds. These separate the line and mode gate from the chunk copy and from the 8- versus 16-cycle stall. A second pulse sent during a copy, and a new start strobe sent during a copy, show whether events that arrive while active are really dropped. A write monitor follows the expected addresses and data, so it catches addresses that do not carry over between chunks. Random pulse trains with random lines and modes are compared against a bench model of chunk counts and stall lengths. A start with a length of 20 and a pulse with nothing left to move check the length rounding and the empty case.

// File: rtl/ldma_pkg.sv
package ldma_pkg;
  typedef struct packed {
    logic loadCfg;
    logic stepAddr;
    logic dropChunk;
  } ldmaStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_STALL = 2'd3
  } ldmaState_t;
endpackage

// File: rtl/ldma_datapath.sv
module ldma_datapath #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int LEN_W = 16,
  parameter int CHUNK_BYTES = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ldma_pkg::ldmaStrobe_t  strobe,
  input  logic [ADDR_W-1:0]      startSrc,
  input  logic [ADDR_W-1:0]      startDst,
  input  logic [LEN_W-1:0]       startLen,
  input  logic [DATA_W-1:0]      memRdData,
  output logic [ADDR_W-1:0]      srcAddr,
  output logic [ADDR_W-1:0]      dstAddr,
  output logic [DATA_W-1:0]      wrData,
  output logic                   lenZero
);
  localparam int LOW_W = $clog2(CHUNK_BYTES);
  localparam logic [LEN_W-1:0] CHUNK_LEN = LEN_W'(CHUNK_BYTES);

  logic [LEN_W-1:0] lenQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcAddr <= '0;
      dstAddr <= '0;
      lenQ    <= '0;
    end else if (strobe.loadCfg) begin
      srcAddr <= startSrc;
      dstAddr <= startDst;
      lenQ    <= {startLen[LEN_W-1:LOW_W], {LOW_W{1'b0}}};
    end else begin
      if (strobe.stepAddr) begin
        srcAddr <= srcAddr + 1'b1;
        dstAddr <= dstAddr + 1'b1;
      end
      if (strobe.dropChunk) lenQ <= lenQ - CHUNK_LEN;
    end
  end

  assign wrData  = memRdData;
  assign lenZero = (lenQ == '0);

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stepAddr && !strobe.loadCfg) |=> (srcAddr == $past(srcAddr) + 1'b1)
      && (dstAddr == $past(dstAddr) + 1'b1)); // R3
  AST_LEN_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.dropChunk && !strobe.loadCfg) |=> (lenQ == $past(lenQ) - CHUNK_LEN)); // R4
  AST_LEN_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    lenQ[LOW_W-1:0] == '0); // R4
endmodule

// File: rtl/ldma_ctrl.sv
module ldma_ctrl #(
  parameter int LINE_W = 8,
  parameter int VISIBLE_LINES = 144,
  parameter int CHUNK_BYTES = 16,
  parameter int STALL_BASE = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   blankPulse,
  input  logic [LINE_W-1:0]      lineNum,
  input  logic                   blankMode,
  input  logic                   fastClock,
  input  logic                   startReq,
  input  logic                   lenZero,
  output ldma_pkg::ldmaStrobe_t  strobe,
  output logic                   rdEn,
  output logic                   wrEn,
  output logic                   cpuStall
);
  import ldma_pkg::*;

  localparam int BYTE_W = $clog2(CHUNK_BYTES);
  localparam int STALL_W = $clog2(2 * STALL_BASE);
  localparam logic [BYTE_W-1:0] LAST_BYTE = BYTE_W'(CHUNK_BYTES - 1);
  localparam logic [STALL_W-1:0] STALL_SLOW = STALL_W'(STALL_BASE - 1);
  localparam logic [STALL_W-1:0] STALL_FAST = STALL_W'(2 * STALL_BASE - 1);

  ldmaState_t state, stateNext;
  logic [BYTE_W-1:0] byteCnt;
  logic [STALL_W-1:0] stallCnt;
  logic eligible;

  assign eligible = blankPulse && blankMode && !lenZero &&
                    (lineNum < LINE_W'(VISIBLE_LINES));

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:  if (eligible) stateNext = ST_READ;
      ST_READ:  stateNext = ST_WRITE;
      ST_WRITE: stateNext = (byteCnt == LAST_BYTE) ? ST_STALL : ST_READ;
      ST_STALL: if (stallCnt == '0) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      byteCnt  <= '0;
      stallCnt <= '0;
    end else begin
      state <= stateNext;
      if (state == ST_IDLE) byteCnt <= '0;
      else if (state == ST_WRITE) byteCnt <= byteCnt + 1'b1;
      if (state == ST_WRITE && byteCnt == LAST_BYTE)
        stallCnt <= fastClock ? STALL_FAST : STALL_SLOW;
      else if (state == ST_STALL && stallCnt != '0)
        stallCnt <= stallCnt - 1'b1;
    end
  end

  assign rdEn     = (state == ST_READ);
  assign wrEn     = (state == ST_WRITE);
  assign cpuStall = (state == ST_STALL);
  assign strobe.loadCfg   = startReq && (state == ST_IDLE);
  assign strobe.stepAddr  = wrEn;
  assign strobe.dropChunk = wrEn && (byteCnt == LAST_BYTE);

  AST_RD_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(rdEn && wrEn)); // R7
  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> $past(rdEn)); // R7
  AST_STALL_NO_MEM: assert property (@(posedge clk) disable iff (!rstN)
    cpuStall |-> (!rdEn && !wrEn)); // R5
  AST_START_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && $past(state) == ST_IDLE) |-> $past(blankPulse && blankMode && !lenZero)); // R1
  AST_STALL_AFTER_CHUNK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpuStall) |-> $past(wrEn)); // R5
endmodule

// File: rtl/line_gap_dma.sv
module line_gap_dma #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int LEN_W = 16,
  parameter int LINE_W = 8,
  parameter int VISIBLE_LINES = 144,
  parameter int CHUNK_BYTES = 16,
  parameter int STALL_BASE = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              blankPulse,
  input  logic [LINE_W-1:0] lineNum,
  input  logic              blankMode,
  input  logic              fastClock,
  input  logic              startReq,
  input  logic [ADDR_W-1:0] startSrc,
  input  logic [ADDR_W-1:0] startDst,
  input  logic [LEN_W-1:0]  startLen,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic [DATA_W-1:0] memRdData,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              cpuStall,
  output logic              busy
);
  ldma_pkg::ldmaStrobe_t strobe;
  logic lenZero;

  ldma_ctrl #(
    .LINE_W(LINE_W), .VISIBLE_LINES(VISIBLE_LINES),
    .CHUNK_BYTES(CHUNK_BYTES), .STALL_BASE(STALL_BASE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .blankPulse(blankPulse), .lineNum(lineNum),
    .blankMode(blankMode), .fastClock(fastClock), .startReq(startReq),
    .lenZero(lenZero), .strobe(strobe), .rdEn(memRdEn), .wrEn(memWrEn),
    .cpuStall(cpuStall)
  );

  ldma_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .CHUNK_BYTES(CHUNK_BYTES)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .startSrc(startSrc),
    .startDst(startDst), .startLen(startLen), .memRdData(memRdData),
    .srcAddr(memRdAddr), .dstAddr(memWrAddr), .wrData(memWrData),
    .lenZero(lenZero)
  );

  assign busy = !lenZero;

  AST_BUSY_FALLS_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(memWrEn)); // R6
endmodule

// File: tb/line_gap_dma_bench.sv
module line_gap_dma_bench;
  logic clk = 0;
  logic rstN = 0;
  logic blankPulse = 0;
  logic [7:0] lineNum = 0;
  logic blankMode = 0;
  logic fastClock = 0;
  logic startReq = 0;
  logic [15:0] startSrc = 0, startDst = 0, startLen = 0;
  logic memRdEn, memWrEn, cpuStall, busy;
  logic [15:0] memRdAddr, memWrAddr;
  logic [7:0] memRdData = 0, memWrData;

  int checks = 0, errors = 0;
  int wrCount = 0, rdCount = 0, stallCycles = 0, cycles = 0;
  int stallRun = 0, lastRun = 0;
  logic [15:0] expSrc = 0, expDst = 0;
  logic [7:0] mem [0:4095];
  logic [7:0] gold [0:4095];

  always #5 clk = ~clk;

  line_gap_dma u_line_gap_dma (
    .clk(clk), .rstN(rstN), .blankPulse(blankPulse), .lineNum(lineNum),
    .blankMode(blankMode), .fastClock(fastClock), .startReq(startReq),
    .startSrc(startSrc), .startDst(startDst), .startLen(startLen),
    .memRdEn(memRdEn), .memRdAddr(memRdAddr), .memRdData(memRdData),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .cpuStall(cpuStall), .busy(busy)
  );

  always @(posedge clk) begin
    if (memRdEn) memRdData <= mem[memRdAddr[11:0]];
    if (memWrEn) mem[memWrAddr[11:0]] <= memWrData;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // write monitor: R2 data, R3 addresses, R7 write follows read
  logic prevRd = 0;
  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      if (memRdEn) rdCount++;
      if (memWrEn) begin
        wrCount++;
        check(memWrAddr == expDst, "R3 write address", memWrAddr, expDst);
        check(memWrData == gold[expSrc[11:0]], "R2 write data", memWrData, gold[expSrc[11:0]]);
        check(prevRd, "R7 write after read", prevRd, 1);
        expSrc++;
        expDst++;
      end
      if (cpuStall) begin
        stallCycles++;
        stallRun++;
        check(!memRdEn && !memWrEn, "R5 no access in stall", memRdEn, 0);
      end else if (stallRun != 0) begin
        lastRun = stallRun;
        stallRun = 0;
      end
      prevRd = memRdEn;
    end
  end

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doStart(input logic [15:0] s, input logic [15:0] d, input logic [15:0] l);
    startSrc = s; startDst = d; startLen = l; startReq = 1;
    tick(1);
    startReq = 0;
    expSrc = s; expDst = d;
  endtask

  function automatic int stallLen(input bit fast);
    return fast ? 16 : 8;
  endfunction

  function automatic bit accepts(input bit mode, input int line, input int chunksLeft);
    return mode && chunksLeft > 0 && line < 144;
  endfunction

  // pulse, wait for any chunk to finish, compare write and stall deltas
  task automatic pulse(input int line, input bit mode, input bit fast,
                       input bit expCopy, input string tag);
    int w0, s0;
    w0 = wrCount; s0 = stallCycles;
    lineNum = 8'(line); blankMode = mode; fastClock = fast; blankPulse = 1;
    tick(1);
    blankPulse = 0;
    tick(55);
    check(wrCount - w0 == (expCopy ? 16 : 0), {tag, " writes"}, wrCount - w0, expCopy ? 16 : 0);
    check(stallCycles - s0 == (expCopy ? stallLen(fast) : 0), {tag, " stall"},
          stallCycles - s0, expCopy ? stallLen(fast) : 0);
  endtask

  initial begin
    int seed;
    int left;
    seed = 32'h5eed_0042;
    void'($urandom(seed));
    for (int i = 0; i < 4096; i++) begin
      mem[i] = 8'($urandom);
      gold[i] = mem[i];
    end
    tick(3);
    rstN = 1;
    tick(1);
    check(!busy && !cpuStall && !memRdEn && !memWrEn, "R6 reset idle", busy, 0);

    // R1: pulse with no length does nothing
    pulse(10, 1, 0, 0, "R1 empty");

    doStart(16'h0100, 16'h0800, 16'd48);
    check(busy, "R6 busy after start", busy, 1);
    pulse(10, 1, 0, 1, "R2 line 10 slow");
    check(lastRun == 8, "R5 slow stall run", lastRun, 8);
    pulse(144, 1, 0, 0, "R1 line 144");
    pulse(143, 0, 0, 0, "R1 mode off");
    pulse(143, 1, 1, 1, "R3 line 143 fast");
    check(lastRun == 16, "R5 fast stall run", lastRun, 16);
    check(busy, "R4 one chunk left", busy, 1);

    // R8: second pulse and new start during copy are ignored
    lineNum = 5; blankMode = 1; fastClock = 0; blankPulse = 1;
    tick(1);
    blankPulse = 0;
    tick(4);
    blankPulse = 1;
    startSrc = 16'h0300; startDst = 16'h0C00; startLen = 16'd160; startReq = 1;
    tick(1);
    blankPulse = 0; startReq = 0;
    tick(60);
    check(wrCount == 48, "R8 repeat pulse ignored", wrCount, 48);
    check(!busy, "R6 busy low after last chunk", busy, 0);
    check(!busy, "R8 start ignored (len unchanged)", busy, 0);
    pulse(20, 1, 0, 0, "R4 length exhausted");

    // R4: low bits of length ignored
    doStart(16'h0200, 16'h0900, 16'd20);
    pulse(30, 1, 0, 1, "R4 len 20 one chunk");
    check(!busy, "R4 len 20 done", busy, 0);

    // random pulse trains
    for (int t = 0; t < 6; t++) begin
      left = 1 + int'($urandom_range(6));
      doStart(16'($urandom_range(63) * 16), 16'h0800 + 16'($urandom_range(63) * 16),
              16'(left * 16 + int'($urandom_range(15))));
      for (int p = 0; p < 12; p++) begin
        int ln;
        bit md, fs, acc;
        ln = int'($urandom_range(153));
        md = 1'($urandom_range(3) != 0);
        fs = 1'($urandom_range(1));
        acc = accepts(md, ln, left);
        pulse(ln, md, fs, acc, "R1 random");
        if (acc) left--;
        check(busy == (left > 0), "R6 random busy", busy, left > 0);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule